// File: doc/BRIEF.md
# Load Queue Snoop Invalidation Checker

This block reacts to an external invalidation snoop by walking the live entries of a circular load queue. Loads that have already computed a physical address and touch the invalidated cache block are flagged. Other logic may have set a "possible ordering violation" mark on a load earlier. Such a load is told to re-execute. Any other matching load is only marked as having observed an external snoop, so that a later ordering check can act on it.

The queue keeps its entries elsewhere. This block reads the head and tail pointers and the per-entry attributes, one entry per clock cycle. For each entry that must change, it returns a one-cycle set pulse on the matching bit of one of two output vectors. The block size is a run-time input. Both addresses are aligned by clearing the offset bits below that size. A one-cycle done pulse ends every accepted snoop, including one that finds the queue empty.

Top module: `ldq_snoop_scan`

## Requirements
- R1: After reset, `busy`, `scan_done`, `reexec_set` and `snoop_hit_set` are all zero.
- R2: A load matches when `paddr & ~(blk_size-1)` equals `snoop_addr & ~(blk_size-1)`. Addresses that differ only below the block size match, and addresses that differ at or above it do not. `blk_size` must be a nonzero power of two whenever a snoop is accepted.
- R3: A snoop accepted while `q_head == q_tail` examines no entry. `scan_done` is high for one cycle immediately after the accepting clock edge.
- R4: The walk visits indices head+1 up to, but not including, tail. The entry at head is never flagged. `scan_done` rises after the N-th clock edge following the accepting edge, where N = (tail − head) mod DEPTH, and it lasts one cycle. `busy` is low when it does.
- R5: Indices wrap modulo DEPTH, so a tail numerically below the head scans across the top of the queue.
- R6: An entry whose address-valid bit is 0, or whose uncacheable bit is 1, is never flagged.
- R7: A matching eligible entry with its possible-violation bit set gets a one-cycle pulse on `reexec_set[idx]`.
- R8: A matching eligible entry with its possible-violation bit clear gets a one-cycle pulse on `snoop_hit_set[idx]`.
- R9: At most one bit across both set vectors is high in any cycle, and each pulse follows the cycle in which its entry was examined.
- R10: A snoop strobe that arrives while `busy` is high is ignored. It produces no flag and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_size | input | ADDR_W | Cache block size in bytes (power of two) |
| snoop_vld | input | 1 | Invalidation snoop strobe |
| snoop_addr | input | ADDR_W | Address of the invalidated line |
| q_head | input | $clog2(DEPTH) | Index of the oldest load |
| q_tail | input | $clog2(DEPTH) | Index one past the youngest load |
| ent_addr_ok | input | DEPTH | Per-entry: effective address computed |
| ent_uncached | input | DEPTH | Per-entry: uncacheable access |
| ent_maybe_viol | input | DEPTH | Per-entry: possible-violation mark |
| ent_paddr | input | DEPTH*ADDR_W | Per-entry physical address, entry i in bits [i*ADDR_W +: ADDR_W] |
| busy | output | 1 | A walk is in progress |
| scan_done | output | 1 | One-cycle end-of-snoop pulse |
| reexec_set | output | DEPTH | One-cycle per-entry re-execute set pulse |
| snoop_hit_set | output | DEPTH | One-cycle per-entry snoop-seen set pulse |

## Verification
Every cycle, the assertions confirm four things: the two pulse vectors never carry more than one bit between them, the head entry and ineligible entries are never flagged, a snoop arriving mid-walk leaves the captured pointers untouched, and every accepted snoop sees a nonzero block size. Other behaviours need the bench's directed scenarios, because they depend on the full queue contents. These are which entries a given block size groups together, the exact split between re-execute and snoop-seen flags, the done latency for empty, single-entry and wrapped queues, and the absence of any effect from an ignored strobe.

// File: rtl/ldq_snoop_pkg.sv
package ldq_snoop_pkg;
  typedef enum logic [0:0] {
    SCAN_IDLE = 1'b0,
    SCAN_WALK = 1'b1
  } scan_state_e;

  typedef struct packed {
    logic addr_ok;
    logic uncached;
    logic maybe_viol;
  } ent_attr_t;
endpackage

// File: rtl/ldq_blk_cmp.sv
module ldq_blk_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [ADDR_W-1:0] blk_size,
  output logic              same_blk
);
  logic [ADDR_W-1:0] align_mask;

  always_comb begin
    align_mask = ~(blk_size - {{(ADDR_W-1){1'b0}}, 1'b1});
    same_blk   = ((addr_a & align_mask) == (addr_b & align_mask));
  end
endmodule

// File: rtl/ldq_scan_ctrl.sv
module ldq_scan_ctrl
  import ldq_snoop_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [IDX_W-1:0] head,
  input  logic [IDX_W-1:0] tail,
  output logic             accept,
  output logic             busy,
  output logic             examine,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] head_q,
  output logic             done
);
  scan_state_e state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, tail_q, tail_d, head_d;
  logic done_q, done_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    tail_d  = tail_q;
    head_d  = head_q;
    done_d  = 1'b0;
    accept  = 1'b0;
    examine = 1'b0;
    case (state_q)
      SCAN_IDLE: begin
        if (req) begin
          accept = 1'b1;
          head_d = head;
          tail_d = tail;
          idx_d  = head + {{(IDX_W-1){1'b0}}, 1'b1};
          if (head == tail) done_d = 1'b1;
          else              state_d = SCAN_WALK;
        end
      end
      SCAN_WALK: begin
        if (idx_q == tail_q) begin
          done_d  = 1'b1;
          state_d = SCAN_IDLE;
        end else begin
          examine = 1'b1;
          idx_d   = idx_q + {{(IDX_W-1){1'b0}}, 1'b1};
        end
      end
      default: state_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      idx_q   <= '0;
      tail_q  <= '0;
      head_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (accept || examine) idx_q <= idx_d;
      if (accept) begin
        tail_q <= tail_d;
        head_q <= head_d;
      end
    end
  end

  assign busy    = (state_q == SCAN_WALK);
  assign cur_idx = idx_q;
  assign done    = done_q;

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> $stable(head_q)); // R10
endmodule

// File: rtl/ldq_flag_pulse.sv
module ldq_flag_pulse #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             examine,
  input  logic [IDX_W-1:0] idx,
  input  logic             eligible,
  input  logic             blk_hit,
  input  logic             maybe_viol,
  output logic [DEPTH-1:0] reexec_set,
  output logic [DEPTH-1:0] hit_set
);
  logic flag_now;
  logic [DEPTH-1:0] re_d, hit_d, re_q, hit_q;

  assign flag_now = examine && eligible && blk_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_comb begin
      re_d[g]  = flag_now && (idx == IDX_W'(g)) && maybe_viol;
      hit_d[g] = flag_now && (idx == IDX_W'(g)) && !maybe_viol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        re_q[g]  <= 1'b0;
        hit_q[g] <= 1'b0;
      end else begin
        re_q[g]  <= re_d[g];
        hit_q[g] <= hit_d[g];
      end
    end
  end

  assign reexec_set = re_q;
  assign hit_set    = hit_q;

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({re_q, hit_q})); // R9
  AST_KIND_FROM_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (|re_q) |-> $past(maybe_viol && examine)); // R7
endmodule

// File: rtl/ldq_snoop_scan.sv
module ldq_snoop_scan
  import ldq_snoop_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       blk_size,
  input  logic                    snoop_vld,
  input  logic [ADDR_W-1:0]       snoop_addr,
  input  logic [IDX_W-1:0]        q_head,
  input  logic [IDX_W-1:0]        q_tail,
  input  logic [DEPTH-1:0]        ent_addr_ok,
  input  logic [DEPTH-1:0]        ent_uncached,
  input  logic [DEPTH-1:0]        ent_maybe_viol,
  input  logic [DEPTH*ADDR_W-1:0] ent_paddr,
  output logic                    busy,
  output logic                    scan_done,
  output logic [DEPTH-1:0]        reexec_set,
  output logic [DEPTH-1:0]        snoop_hit_set
);
  logic              accept, examine, blk_hit;
  logic [IDX_W-1:0]  cur_idx, head_q;
  logic [ADDR_W-1:0] snp_addr_q, blk_size_q, cur_paddr;
  ent_attr_t         cur_attr;

  ldq_scan_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (snoop_vld),
    .head    (q_head),
    .tail    (q_tail),
    .accept  (accept),
    .busy    (busy),
    .examine (examine),
    .cur_idx (cur_idx),
    .head_q  (head_q),
    .done    (scan_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snp_addr_q <= '0;
      blk_size_q <= '0;
    end else if (accept) begin
      snp_addr_q <= snoop_addr;
      blk_size_q <= blk_size;
    end
  end

  always_comb begin
    cur_paddr           = ent_paddr[cur_idx*ADDR_W +: ADDR_W];
    cur_attr.addr_ok    = ent_addr_ok[cur_idx];
    cur_attr.uncached   = ent_uncached[cur_idx];
    cur_attr.maybe_viol = ent_maybe_viol[cur_idx];
  end

  ldq_blk_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .addr_a   (cur_paddr),
    .addr_b   (snp_addr_q),
    .blk_size (blk_size_q),
    .same_blk (blk_hit)
  );

  ldq_flag_pulse #(.DEPTH(DEPTH)) u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .examine    (examine),
    .idx        (cur_idx),
    .eligible   (cur_attr.addr_ok && !cur_attr.uncached),
    .blk_hit    (blk_hit),
    .maybe_viol (cur_attr.maybe_viol),
    .reexec_set (reexec_set),
    .hit_set    (snoop_hit_set)
  );

  AST_BLK_SIZE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (blk_size != '0) && ((blk_size & (blk_size - 1'b1)) == '0)); // R2
  AST_HEAD_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !(reexec_set[head_q] || snoop_hit_set[head_q])); // R4

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    AST_SKIP_INELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (reexec_set[g] || snoop_hit_set[g]) |-> $past(ent_addr_ok[g] && !ent_uncached[g])); // R6
  end
endmodule

// File: tb/test_ldq_snoop_scan.sv
module test_ldq_snoop_scan;
  localparam int DEPTH = 8;
  localparam int ADDR_W = 32;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] blk_size = 32'd64;
  logic snoop_vld = 1'b0;
  logic [ADDR_W-1:0] snoop_addr = '0;
  logic [IDX_W-1:0] q_head = '0, q_tail = '0;
  logic [DEPTH-1:0] ent_addr_ok = '0, ent_uncached = '0, ent_maybe_viol = '0;
  logic [ADDR_W-1:0] pa [DEPTH];
  logic [DEPTH*ADDR_W-1:0] ent_paddr;
  logic busy, scan_done;
  logic [DEPTH-1:0] reexec_set, snoop_hit_set;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < DEPTH; i++) ent_paddr[i*ADDR_W +: ADDR_W] = pa[i];

  ldq_snoop_scan #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_ldq_snoop_scan (
    .clk(clk), .rst_n(rst_n), .blk_size(blk_size), .snoop_vld(snoop_vld),
    .snoop_addr(snoop_addr), .q_head(q_head), .q_tail(q_tail),
    .ent_addr_ok(ent_addr_ok), .ent_uncached(ent_uncached),
    .ent_maybe_viol(ent_maybe_viol), .ent_paddr(ent_paddr),
    .busy(busy), .scan_done(scan_done), .reexec_set(reexec_set),
    .snoop_hit_set(snoop_hit_set)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Expected flags and walk length derived from the requirements.
  task automatic model(input logic [ADDR_W-1:0] sa, output logic [DEPTH-1:0] e_re,
                       output logic [DEPTH-1:0] e_hit, output int e_n);
    logic [ADDR_W-1:0] m;
    m = ~(blk_size - 1);
    e_re = '0; e_hit = '0;
    e_n = (int'(q_tail) - int'(q_head) + DEPTH) % DEPTH;
    for (int k = 1; k < e_n; k++) begin
      int ix;
      ix = (int'(q_head) + k) % DEPTH;
      if (ent_addr_ok[ix] && !ent_uncached[ix] && ((pa[ix] & m) == (sa & m))) begin
        if (ent_maybe_viol[ix]) e_re[ix] = 1'b1;
        else                    e_hit[ix] = 1'b1;
      end
    end
  endtask

  // Issue one snoop, optionally strobe a second one mid-walk, and check outcome.
  task automatic run_snoop(input string tag, input logic [ADDR_W-1:0] sa,
                           input int poke_at, input logic [ADDR_W-1:0] poke_addr);
    logic [DEPTH-1:0] e_re, e_hit, g_re, g_hit;
    int e_n, done_at, done_cnt, multi;
    model(sa, e_re, e_hit, e_n);
    @(negedge clk);
    snoop_vld = 1'b1; snoop_addr = sa;
    @(negedge clk);
    snoop_vld = 1'b0;
    g_re = '0; g_hit = '0; done_at = -1; done_cnt = 0; multi = 0;
    for (int k = 0; k < DEPTH + 4; k++) begin
      if (scan_done) begin
        done_cnt++;
        if (done_at < 0) done_at = k;
      end
      if ($countones({reexec_set, snoop_hit_set}) > 1) multi++;
      g_re |= reexec_set; g_hit |= snoop_hit_set;
      if (k == poke_at) begin snoop_vld = 1'b1; snoop_addr = poke_addr; end
      @(negedge clk);
      snoop_vld = 1'b0;
    end
    chk(done_at == e_n, {tag, " R4 done latency"}, done_at, e_n);
    chk(done_cnt == 1, {tag, " R10 single done"}, done_cnt, 1);
    chk(g_re == e_re, {tag, " R7 reexec flags"}, g_re, e_re);
    chk(g_hit == e_hit, {tag, " R8 snoop-hit flags"}, g_hit, e_hit);
    chk(multi == 0, {tag, " R9 one pulse per cycle"}, multi, 0);
    chk(!busy, {tag, " R4 idle after walk"}, busy, 0);
  endtask

  task automatic fill(input logic [ADDR_W-1:0] base);
    for (int i = 0; i < DEPTH; i++) pa[i] = base + 32'(i * 4);
    ent_addr_ok = '1; ent_uncached = '0; ent_maybe_viol = '0;
  endtask

  task automatic t_reset;
    chk(!busy && !scan_done, "R1 reset control", {busy, scan_done}, 0);
    chk(reexec_set == '0 && snoop_hit_set == '0, "R1 reset flags",
        {reexec_set, snoop_hit_set}, 0);
  endtask

  task automatic t_mixed; // R6 R7 R8: eligibility and flag kind
    fill(32'h1000_0040);
    blk_size = 64; q_head = 0; q_tail = 6;
    pa[1] = 32'h1000_007C;
    ent_maybe_viol[2] = 1'b1;
    ent_addr_ok[3] = 1'b0;
    ent_uncached[4] = 1'b1;
    pa[5] = 32'h1000_0080;
    ent_maybe_viol[6] = 1'b1;
    run_snoop("mixed R6", 32'h1000_0041, -1, '0);
  endtask

  task automatic t_empty; // R3
    fill(32'h2000_0000);
    q_head = 3; q_tail = 3;
    run_snoop("empty R3", 32'h2000_0000, -1, '0);
  endtask

  task automatic t_single; // R4: only the head entry, never checked
    fill(32'h2000_0000);
    ent_maybe_viol = '1;
    q_head = 5; q_tail = 6;
    run_snoop("single R4", 32'h2000_0000, -1, '0);
  endtask

  task automatic t_wrap; // R5
    fill(32'h4000_0000);
    q_head = 6; q_tail = 3;
    ent_maybe_viol[0] = 1'b1;
    ent_maybe_viol[7] = 1'b1;
    pa[1] = 32'h4000_1000;
    run_snoop("wrap R5", 32'h4000_0010, -1, '0);
  endtask

  task automatic t_blk_size; // R2
    fill(32'h3000_0000);
    pa[0] = 32'h3000_0010; pa[1] = 32'h3000_0030; pa[2] = 32'h3000_0110;
    q_head = 7; q_tail = 3;
    blk_size = 16;  run_snoop("blk16 R2", 32'h3000_0000, -1, '0);
    blk_size = 64;  run_snoop("blk64 R2", 32'h3000_0000, -1, '0);
    blk_size = 512; run_snoop("blk512 R2", 32'h3000_0000, -1, '0);
    blk_size = 64;
  endtask

  task automatic t_busy_ignore; // R10
    fill(32'h5000_0000);
    q_head = 0; q_tail = 5;
    run_snoop("busy R10", 32'h6000_0000, 1, 32'h5000_0000);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) pa[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mixed();
    t_empty();
    t_single();
    t_wrap();
    t_blk_size();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule